// File: doc/BRIEF.md
# Front-Panel Status Indicator Controller

This block drives the status lamps of an instrument front panel: one trigger lamp and a parameterized set of alert lamps (two by default). The trigger lamp has three states, on, blinking and off. A comparator output reports whether the trigger signal is above its threshold. A slope-select input decides whether "above" means lit or dark. When the comparator keeps switching within a short programmable window, the lamp blinks instead.

Alert lamps flash while their request inputs are held and never light steadily. Blink timing is not produced inside the block. It is taken from the low-order scan-select lines of the display scanner: every time those lines wrap from their highest code back to zero, a registered blink phase toggles. A display-blank input darkens every lamp. The block also returns the blank as an inverted, registered output, so a missing controller leaves the display dark.

The block has no data stream, so it has no valid/ready handshake. All pins are plain levels sampled on the rising clock edge. The exception is the comparator input, which is asynchronous.

Top module: `panel_lamp_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) clears every lamp output to 0, sets `trig_mode` to OFF (code 0) and drives `blank_n_out` to 0.
- R2: With `slope_neg`=0 and no comparator activity, `trig_mode` is ON (code 1) and `trig_lamp` is steadily 1 while `cmp_in` is high. While `cmp_in` is low, `trig_mode` is OFF (code 0) and `trig_lamp` is steadily 0.
- R3: With `slope_neg`=1 the sense is inverted: the lamp is ON (code 1, lit) while `cmp_in` is low and OFF (code 0, dark) while it is high.
- R4: Two edges of the synchronized comparator less than `win_len` scan wraps apart put the trigger lamp in BLINK (code 2). In that state `trig_lamp` follows the blink phase with a 50% duty cycle.
- R5: A single comparator edge does not cause BLINK. Neither do edges separated by at least `win_len` scan wraps.
- R6: BLINK is held until `win_len` scan wraps have passed without a further edge, and the lamp then returns to ON or OFF. An edge that falls in the same cycle as a wrap restarts the count.
- R7: Each alert lamp is lit only while its `alert_req` bit is high and the blink phase is lit. With the request held, it is lit exactly half of the time and is never steadily on.
- R8: The blink phase toggles each time `scan_sel` goes from all ones to zero. With `scan_sel` advancing by one per clock and 2 scan bits, a blinking lamp is lit 4 cycles and dark 4 cycles.
- R9: While `blank_in` is 1, every lamp output is 0 from the next cycle on. `blank_n_out` equals the inverse of `blank_in` one cycle later.
- R10: With `win_len`=0, comparator activity never produces BLINK.
- R11: `cmp_in` passes a two-flop synchronizer. A change applied before rising edge 1 appears on `trig_mode` and `trig_lamp` after rising edge 3, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Asynchronous comparator output, 1 = trigger above threshold |
| slope_neg | input | 1 | 1 = negative slope selected |
| alert_req | input | N_ALERT | Alert lamp requests, one bit per lamp |
| scan_sel | input | SCAN_W | Low-order display scan-select lines |
| blank_in | input | 1 | Display blank, 1 = blanked |
| win_len | input | WIN_W | Activity window length in scan wraps |
| trig_mode | output | 2 | Trigger lamp state: 0 OFF, 1 ON, 2 BLINK |
| trig_lamp | output | 1 | Trigger lamp drive |
| alert_lamp | output | N_ALERT | Alert lamp drives |
| blank_n_out | output | 1 | Registered inverted blank |

## Verification
Two things can happen in the same cycle: a comparator edge reaches the activity detector, and the scan lines wrap. If they coincide, the edge must win, so the quiet count starts again from zero. The bench provokes this by aligning the final comparator edge to each of the four scan-select codes in turn, which makes one of the alignments land the edge exactly on a wrap. For every alignment it checks that BLINK is still present well inside the window and gone once the full window has passed. Blanking is also applied while both the blinking trigger lamp and the alert lamps are active, to confirm that the forced-off path overrides both.

// File: rtl/lamp_pkg.sv
package lamp_pkg;
  typedef enum logic [1:0] {
    TRIG_OFF   = 2'd0,
    TRIG_ON    = 2'd1,
    TRIG_BLINK = 2'd2
  } trig_mode_e;
endpackage

// File: rtl/lamp_sync.sv
module lamp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lamp_phase.sv
module lamp_phase #(
  parameter int SCAN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SCAN_W-1:0] scan_sel,
  output logic              wrap,
  output logic              phase
);
  localparam logic [SCAN_W-1:0] SCAN_LAST = '1;

  logic [SCAN_W-1:0] scan_q;

  // A wrap is the step from the highest scan code back to zero
  assign wrap = (scan_q == SCAN_LAST) && (scan_sel == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q <= '0;
      phase  <= 1'b0;
    end else begin
      scan_q <= scan_sel;
      if (wrap) phase <= ~phase;
    end
  end
endmodule

// File: rtl/lamp_activity.sv
module lamp_activity #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             wrap,
  input  logic [WIN_W-1:0] win_len,
  output logic             active
);
  localparam int CW = WIN_W + 1;

  logic             lvl_q;
  logic             edge_det;
  logic             armed;
  logic [WIN_W-1:0] quiet;
  logic [CW-1:0]    quiet_nx;

  assign edge_det = lvl ^ lvl_q;
  assign quiet_nx = {1'b0, quiet} + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      armed  <= 1'b0;
      active <= 1'b0;
      quiet  <= '0;
    end else begin
      lvl_q <= lvl;
      if (edge_det) begin
        // an edge has priority over a coincident wrap: the window restarts
        if (armed) active <= 1'b1;
        armed <= (win_len != '0);
        quiet <= '0;
      end else if (wrap && armed) begin
        if (quiet_nx >= {1'b0, win_len}) begin
          armed  <= 1'b0;
          active <= 1'b0;
          quiet  <= '0;
        end else begin
          quiet <= quiet_nx[WIN_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/panel_lamp_ctrl.sv
module panel_lamp_ctrl #(
  parameter int SCAN_W  = 2,
  parameter int WIN_W   = 8,
  parameter int N_ALERT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmp_in,
  input  logic               slope_neg,
  input  logic [N_ALERT-1:0] alert_req,
  input  logic [SCAN_W-1:0]  scan_sel,
  input  logic               blank_in,
  input  logic [WIN_W-1:0]   win_len,
  output logic [1:0]         trig_mode,
  output logic               trig_lamp,
  output logic [N_ALERT-1:0] alert_lamp,
  output logic               blank_n_out
);
  import lamp_pkg::*;

  logic       cmp_s;
  logic       wrap;
  logic       phase;
  logic       active;
  logic       lit_level;
  trig_mode_e mode_nx;

  lamp_sync #(.W(1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_in),
    .q   (cmp_s)
  );

  lamp_phase #(.SCAN_W(SCAN_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .scan_sel (scan_sel),
    .wrap     (wrap),
    .phase    (phase)
  );

  lamp_activity #(.WIN_W(WIN_W)) u_act (
    .clk     (clk),
    .rst     (rst),
    .lvl     (cmp_s),
    .wrap    (wrap),
    .win_len (win_len),
    .active  (active)
  );

  assign lit_level = cmp_s ^ slope_neg;

  always_comb begin
    if (active)         mode_nx = TRIG_BLINK;
    else if (lit_level) mode_nx = TRIG_ON;
    else                mode_nx = TRIG_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_mode   <= TRIG_OFF;
      trig_lamp   <= 1'b0;
      blank_n_out <= 1'b0;
    end else begin
      trig_mode   <= mode_nx;
      trig_lamp   <= !blank_in &&
                     ((mode_nx == TRIG_ON) || ((mode_nx == TRIG_BLINK) && phase));
      blank_n_out <= !blank_in;
    end
  end

  for (genvar g = 0; g < N_ALERT; g++) begin : g_alert
    always_ff @(posedge clk) begin
      if (rst) alert_lamp[g] <= 1'b0;
      else     alert_lamp[g] <= !blank_in && alert_req[g] && phase;
    end
  end
endmodule

// File: rtl/panel_lamp_ctrl_chk.sv
module panel_lamp_ctrl_chk #(
  parameter int N_ALERT = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               blank_in,
  input logic [N_ALERT-1:0] alert_req,
  input logic [1:0]         trig_mode,
  input logic               trig_lamp,
  input logic [N_ALERT-1:0] alert_lamp,
  input logic               blank_n_out
);
  // R9: blanking darkens every lamp on the next cycle
  a_r9_blank_dark: assert property (@(posedge clk) disable iff (rst)
    blank_in |=> (!trig_lamp && alert_lamp == '0));

  // R9: inverted blank output follows its input by one cycle
  a_r9_blank_inv: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (blank_n_out == !$past(blank_in)));

  // R7: an alert lamp is lit only after its request was present
  a_r7_alert_needs_req: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((alert_lamp & ~$past(alert_req)) == '0));

  // R2: OFF state never lights the trigger lamp
  a_r2_off_dark: assert property (@(posedge clk) disable iff (rst)
    (trig_mode == 2'd0) |-> !trig_lamp);

  // R2: ON state lights the lamp unless blanked
  a_r2_on_lit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && trig_mode == 2'd1 && !$past(blank_in)) |-> trig_lamp);

  // R4: the mode encoding stays within its three states
  a_r4_mode_legal: assert property (@(posedge clk) disable iff (rst)
    trig_mode != 2'd3);
endmodule

bind panel_lamp_ctrl panel_lamp_ctrl_chk #(.N_ALERT(N_ALERT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .blank_in    (blank_in),
  .alert_req   (alert_req),
  .trig_mode   (trig_mode),
  .trig_lamp   (trig_lamp),
  .alert_lamp  (alert_lamp),
  .blank_n_out (blank_n_out)
);

// File: tb/test_panel_lamp_ctrl.sv
module test_panel_lamp_ctrl;
  localparam int SCAN_W = 2;
  localparam int WIN_W = 8;
  localparam int N_ALERT = 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cmp_in = 1'b0;
  logic               slope_neg = 1'b0;
  logic [N_ALERT-1:0] alert_req = '0;
  logic [SCAN_W-1:0]  scan_sel = '0;
  logic               blank_in = 1'b0;
  logic [WIN_W-1:0]   win_len = 8'd4;
  logic [1:0]         trig_mode;
  logic               trig_lamp;
  logic [N_ALERT-1:0] alert_lamp;
  logic               blank_n_out;
  logic               scan_run = 1'b0;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  panel_lamp_ctrl #(.SCAN_W(SCAN_W), .WIN_W(WIN_W), .N_ALERT(N_ALERT)) i_panel_lamp_ctrl (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .slope_neg(slope_neg),
    .alert_req(alert_req), .scan_sel(scan_sel), .blank_in(blank_in),
    .win_len(win_len), .trig_mode(trig_mode), .trig_lamp(trig_lamp),
    .alert_lamp(alert_lamp), .blank_n_out(blank_n_out)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      if (scan_run) scan_sel = scan_sel + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    cmp_in = 1'b0;
    cyc(4 * int'(win_len) + 12);
  endtask

  task automatic t_reset();
    cyc(3);
    chk(trig_mode == 2'd0, "R1 mode", trig_mode, 0);
    chk(trig_lamp == 1'b0 && alert_lamp == '0, "R1 lamps", {trig_lamp, alert_lamp}, 0);
    chk(blank_n_out == 1'b0, "R1 blank_n", blank_n_out, 0);
    rst = 1'b0;
    scan_run = 1'b1;
    cyc(2);
  endtask

  task automatic t_sync_latency();
    slope_neg = 1'b0;
    cmp_in = 1'b0;
    cyc(6);
    cmp_in = 1'b1;
    cyc(2);
    chk(trig_mode == 2'd0, "R11 before edge 3", trig_mode, 0);
    cyc(1);
    chk(trig_mode == 2'd1 && trig_lamp, "R11 after edge 3", trig_mode, 1);
    settle();
  endtask

  task automatic t_slope(input bit neg, input string req);
    int ones;
    slope_neg = neg;
    win_len = 8'd4;
    for (int v = 0; v < 2; v++) begin
      cmp_in = v[0];
      cyc(4 * 4 + 12);
      ones = 0;
      for (int i = 0; i < 16; i++) begin
        ones += int'(trig_lamp);
        cyc(1);
      end
      chk(trig_mode == 2'(v[0] ^ neg), req, trig_mode, int'(v[0] ^ neg));
      chk(ones == (((v[0] ^ neg) != 0) ? 16 : 0), req, ones, ((v[0] ^ neg) != 0) ? 16 : 0);
    end
    slope_neg = 1'b0;
    settle();
  endtask

  task automatic t_blink_duty();
    int ones;
    int run;
    int max_run;
    win_len = 8'd20;
    cmp_in = 1'b1;
    cyc(3);
    cmp_in = 1'b0;
    cyc(6);
    ones = 0; run = 0; max_run = 0;
    for (int i = 0; i < 32; i++) begin
      chk(trig_mode == 2'd2, "R4 mode blink", trig_mode, 2);
      ones += int'(trig_lamp);
      run = trig_lamp ? run + 1 : 0;
      if (run > max_run) max_run = run;
      cyc(1);
    end
    chk(ones == 16, "R4 blink duty", ones, 16);
    chk(max_run == 4, "R8 lit run length", max_run, 4);
    win_len = 8'd4;
    settle();
  endtask

  task automatic t_no_blink_single_and_far();
    int bad;
    win_len = 8'd2;
    bad = 0;
    cmp_in = 1'b1;
    for (int i = 0; i < 30; i++) begin
      bad += int'(trig_mode == 2'd2);
      cyc(1);
    end
    chk(bad == 0, "R5 single edge", bad, 0);
    cmp_in = 1'b0;
    for (int i = 0; i < 30; i++) begin
      bad += int'(trig_mode == 2'd2);
      cyc(1);
    end
    chk(bad == 0, "R5 far edges", bad, 0);
    win_len = 8'd4;
    settle();
  endtask

  task automatic t_hold_window();
    win_len = 8'd4;
    for (int k = 0; k < 4; k++) begin
      while (scan_sel != 2'(k)) cyc(1);
      cmp_in = 1'b1;
      cyc(3);
      cmp_in = 1'b0;
      cyc(12);
      chk(trig_mode == 2'd2, "R6 held in window", trig_mode, 2);
      cyc(10);
      chk(trig_mode == 2'd0, "R6 released after window", trig_mode, 0);
      settle();
    end
  endtask

  task automatic t_win_zero();
    int bad;
    win_len = 8'd0;
    bad = 0;
    for (int r = 0; r < 3; r++) begin
      cmp_in = 1'b1;
      cyc(3);
      cmp_in = 1'b0;
      cyc(3);
    end
    for (int i = 0; i < 20; i++) begin
      bad += int'(trig_mode == 2'd2);
      cyc(1);
    end
    chk(bad == 0, "R10 zero window", bad, 0);
    win_len = 8'd4;
    settle();
  endtask

  task automatic t_alert();
    int ones0;
    int ones1;
    alert_req = 2'b01;
    cyc(2);
    ones0 = 0; ones1 = 0;
    for (int i = 0; i < 32; i++) begin
      ones0 += int'(alert_lamp[0]);
      ones1 += int'(alert_lamp[1]);
      cyc(1);
    end
    chk(ones0 == 16, "R7 alert duty", ones0, 16);
    chk(ones1 == 0, "R7 alert no request", ones1, 0);
    alert_req = '0;
    cyc(2);
  endtask

  task automatic t_blank_override();
    int bad;
    win_len = 8'd20;
    alert_req = 2'b11;
    cmp_in = 1'b1;
    cyc(3);
    cmp_in = 1'b0;
    cyc(4);
    blank_in = 1'b1;
    cyc(1);
    chk(blank_n_out == 1'b0, "R9 blank_n low", blank_n_out, 0);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      bad += int'(trig_lamp) + int'(alert_lamp != '0);
      cyc(1);
    end
    chk(bad == 0, "R9 all dark", bad, 0);
    blank_in = 1'b0;
    cyc(1);
    chk(blank_n_out == 1'b1, "R9 blank_n high", blank_n_out, 1);
    alert_req = '0;
    win_len = 8'd4;
    settle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sync_latency();
    t_slope(1'b0, "R2");
    t_slope(1'b1, "R3");
    t_blink_duty();
    t_no_blink_single_and_far();
    t_hold_window();
    t_win_zero();
    t_alert();
    t_blank_override();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule